// File: doc/BRIEF.md
# Flash Command Interface with Status

This block is the command front end and embedded sequencer of one byte-wide flash device. A host talks to it over a simple synchronous bus with a chip enable, a write strobe and a read strobe. Each accepted write is a command byte. One-byte commands switch the read mode between array, identifier and status. Two-write sequences start a byte program or a block erase. The program and erase times are modelled by cycle counters, and the sequencer acts on a small internal byte array.

Reads always return one byte, one cycle after the strobe, flagged by a valid pulse. The host cannot stall this path: there is no back-pressure, and the host must take the byte in the cycle its valid pulse is high. The status byte reports sequencer ready, erase suspended, and three sticky error flags. The ready/busy pin mirrors the sequencer ready bit.

An erase can be parked at the next byte boundary so that other blocks can be read, and then resumed from the byte where it stopped.

Top module: `flash_cmd_status`

## Requirements
- R1: After reset the device is in array read mode, `rdy` is 1, and every array byte reads FFh.
- R2: Command FFh selects array reads, 90h selects identifier reads and 70h selects status reads. The selected mode stays in force across any number of reads until another mode-changing command is accepted.
- R3: In identifier mode only address bit 0 is used: 0 returns 89h and 1 returns A2h.
- R4: Status byte layout: bit 7 = ready (1 ready, 0 busy), bit 6 = erase parked, bit 5 = erase error, bit 4 = program error, bit 3 = low program voltage. Bits 2..0 read 0. The idle value is 80h.
- R5: Setup 40h or 10h, followed by a second write carrying address and data, starts a program. `rdy` falls at that write, and after PROG_CYC cycles the stored byte becomes old AND new.
- R6: While a program or erase runs, every read returns status and every command except B0h is ignored. After the operation ends, reads stay in status mode.
- R7: Setup 20h followed by D0h erases, to FFh, the block selected by the upper BLK_W bits of the confirm address. Other blocks are unchanged.
- R8: A second write other than D0h after 20h sets bits 5 and 4, erases nothing, and selects status mode.
- R9: Bits 5, 4 and 3 are cleared only by command 50h. Mode commands leave them set.
- R10: While any of bits 5..3 is set, a program or erase sequence is consumed without starting: `rdy` stays 1 and the array is unchanged.
- R11: If `vpp_ok` is 0 during a program or erase, the operation stops one cycle later without storing. Bit 3 and the bit of that operation (4 for program, 5 for erase) are set, and the device returns to ready.
- R12: B0h during an erase parks it within ERASE_STEP cycles. Status then reads C0h and `rdy` is 1. Only FFh, 70h and D0h are accepted while parked, and array reads of the parked block return status.
- R13: D0h while parked clears bits 7 and 6 at once and continues the erase from the byte where it stopped, until the whole block is FFh.
- R14: A read strobe with `wr_en` low gives `rd_vld` high for exactly the next cycle, with `rdata` computed from the state at the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable qualifying both strobes |
| wr_en | input | 1 | Command/data write strobe |
| rd_en | input | 1 | Read strobe (ignored when wr_en is high) |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Command or program data |
| vpp_ok | input | 1 | Program voltage is within range |
| rd_vld | output | 1 | Read data valid, one cycle after a read strobe |
| rdata | output | 8 | Read data |
| rdy | output | 1 | 1 = sequencer ready (also while an erase is parked) |

## Verification
The program path is tried with both setup codes and with data that clears different bit sets in one byte. This separates an AND merge from a plain overwrite and shows that both setup codes are decoded. The erase is tried with a setup address in one block and a confirm address in another, and block 0 is read afterwards; this shows which address selects the block and that other blocks are untouched. Further patterns are a bad confirm byte, a program and an erase with errors still pending, and low voltage during each operation. Together they separate the setting, refusal and clearing of each sticky bit. A park and resume sequence with identifier and read commands issued in between shows which commands are accepted while parked, and that the erase finishes the whole block after resuming.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_ID    = 8'h90;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_CLEAR_STAT = 8'h50;
  localparam logic [7:0] OP_ERASE_SET  = 8'h20;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_PARK       = 8'hB0;
  localparam logic [7:0] OP_PROG_A     = 8'h40;
  localparam logic [7:0] OP_PROG_B     = 8'h10;

  localparam logic [7:0] ID_MAKER  = 8'h89;
  localparam logic [7:0] ID_DEVICE = 8'hA2;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_e;
  typedef enum logic [1:0] {PD_NONE, PD_PROG, PD_ERASE} pend_e;
  typedef enum logic [1:0] {WS_IDLE, WS_PROG, WS_ERASE, WS_PARK} wsm_e;
endpackage

// File: rtl/fcs_mem.sv
module fcs_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [7:0]        rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [7:0]        rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/fcs_wsm.sv
module fcs_wsm
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BLK_W      = 2,
  parameter int PROG_CYC   = 12,
  parameter int ERASE_STEP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic              park_req,
  input  logic              resume,
  input  logic              vpp_ok,
  input  logic [7:0]        mem_rd,
  output logic              busy,
  output logic              parked,
  output logic              fail_prog,
  output logic              fail_erase,
  output logic [BLK_W-1:0]  park_blk,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr
);
  localparam int OFF_W = ADDR_W - BLK_W;
  localparam int PCW   = $clog2(PROG_CYC + 1);
  localparam int SCW   = $clog2(ERASE_STEP + 1);
  localparam logic [PCW-1:0]   PC_INIT  = PCW'(PROG_CYC - 1);
  localparam logic [SCW-1:0]   SC_INIT  = SCW'(ERASE_STEP - 1);
  localparam logic [OFF_W-1:0] IDX_LAST = {OFF_W{1'b1}};

  wsm_e              st;
  logic [PCW-1:0]    pcnt;
  logic [SCW-1:0]    scnt;
  logic [ADDR_W-1:0] tgt_addr;
  logic [7:0]        tgt_data;
  logic [BLK_W-1:0]  blk;
  logic [OFF_W-1:0]  idx;
  logic              park_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= WS_IDLE;
      pcnt      <= '0;
      scnt      <= '0;
      tgt_addr  <= '0;
      tgt_data  <= '0;
      blk       <= '0;
      idx       <= '0;
      park_pend <= 1'b0;
    end else begin
      case (st)
        WS_IDLE: begin
          if (start_prog) begin
            st       <= WS_PROG;
            pcnt     <= PC_INIT;
            tgt_addr <= op_addr;
            tgt_data <= op_data;
          end else if (start_erase) begin
            st        <= WS_ERASE;
            blk       <= op_addr[ADDR_W-1 -: BLK_W];
            idx       <= '0;
            scnt      <= SC_INIT;
            park_pend <= 1'b0;
          end
        end
        WS_PROG: begin
          if (!vpp_ok || pcnt == '0) st <= WS_IDLE;
          else pcnt <= pcnt - 1'b1;
        end
        WS_ERASE: begin
          if (park_req) park_pend <= 1'b1;
          if (!vpp_ok) begin
            st        <= WS_IDLE;
            park_pend <= 1'b0;
          end else if (scnt == '0) begin
            idx  <= idx + 1'b1;
            scnt <= SC_INIT;
            if (idx == IDX_LAST) begin
              st        <= WS_IDLE;
              park_pend <= 1'b0;
            end else if (park_pend || park_req) begin
              st        <= WS_PARK;
              park_pend <= 1'b0;
            end
          end else begin
            scnt <= scnt - 1'b1;
          end
        end
        WS_PARK: begin
          if (resume) begin
            st   <= WS_ERASE;
            scnt <= SC_INIT;
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = {blk, idx};
    mem_wdata = 8'hFF;
    if (st == WS_PROG) begin
      mem_we    = vpp_ok && (pcnt == '0);
      mem_waddr = tgt_addr;
      mem_wdata = mem_rd & tgt_data;
    end else if (st == WS_ERASE) begin
      mem_we = vpp_ok && (scnt == '0);
    end
  end

  assign mem_raddr  = tgt_addr;
  assign busy       = (st == WS_PROG) || (st == WS_ERASE);
  assign parked     = (st == WS_PARK);
  assign fail_prog  = (st == WS_PROG) && !vpp_ok;
  assign fail_erase = (st == WS_ERASE) && !vpp_ok;
  assign park_blk   = blk;

  AST_RESUME_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WS_PARK && resume) |=> (st == WS_ERASE)) else $error("resume did not restart erase"); // R13
  AST_PARK_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WS_PARK && !resume) |=> $stable(idx)) else $error("erase position moved while parked"); // R13
  AST_VPP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == WS_PROG || st == WS_ERASE) && !vpp_ok) |=> (st == WS_IDLE)) else $error("low voltage did not stop operation"); // R11
  AST_PARK_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == WS_PARK) |-> ($past(st) == WS_ERASE)) else $error("parked without erase"); // R12
endmodule

// File: rtl/fcs_cui.sv
module fcs_cui
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] wdata,
  input  logic       busy,
  input  logic       parked,
  input  logic       fail_prog,
  input  logic       fail_erase,
  output logic       start_prog,
  output logic       start_erase,
  output logic       park_req,
  output logic       resume,
  output rmode_e     rmode,
  output logic [2:0] err_bits,
  output logic [7:0] status
);
  pend_e pend;
  logic  er_err, pg_err, lv_err;
  logic  err_any, idle_cmd, bad_confirm, clr;

  assign err_any     = er_err | pg_err | lv_err;
  assign idle_cmd    = cmd_wr && (pend == PD_NONE) && !busy && !parked;
  assign start_prog  = cmd_wr && (pend == PD_PROG) && !err_any;
  assign start_erase = cmd_wr && (pend == PD_ERASE) && (wdata == OP_CONFIRM) && !err_any;
  assign bad_confirm = cmd_wr && (pend == PD_ERASE) && (wdata != OP_CONFIRM);
  assign park_req    = cmd_wr && busy && (wdata == OP_PARK);
  assign resume      = cmd_wr && parked && (wdata == OP_CONFIRM);
  assign clr         = idle_cmd && (wdata == OP_CLEAR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      er_err <= 1'b0;
      pg_err <= 1'b0;
      lv_err <= 1'b0;
    end else if (clr) begin
      er_err <= 1'b0;
      pg_err <= 1'b0;
      lv_err <= 1'b0;
    end else begin
      if (fail_prog || fail_erase) lv_err <= 1'b1;
      if (fail_prog || bad_confirm) pg_err <= 1'b1;
      if (fail_erase || bad_confirm) er_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rmode <= RM_ARRAY;
      pend  <= PD_NONE;
    end else if (cmd_wr) begin
      if (pend != PD_NONE) begin
        pend  <= PD_NONE;
        rmode <= RM_STATUS;
      end else if (busy) begin
        rmode <= rmode;
      end else if (parked) begin
        case (wdata)
          OP_READ_ARRAY: rmode <= RM_ARRAY;
          OP_READ_STAT,
          OP_CONFIRM:    rmode <= RM_STATUS;
          default:       rmode <= rmode;
        endcase
      end else begin
        case (wdata)
          OP_READ_ARRAY: rmode <= RM_ARRAY;
          OP_READ_ID:    rmode <= RM_IDENT;
          OP_READ_STAT:  rmode <= RM_STATUS;
          OP_ERASE_SET: begin
            pend  <= PD_ERASE;
            rmode <= RM_STATUS;
          end
          OP_PROG_A,
          OP_PROG_B: begin
            pend  <= PD_PROG;
            rmode <= RM_STATUS;
          end
          default: rmode <= rmode;
        endcase
      end
    end
  end

  assign err_bits = {er_err, pg_err, lv_err};
  assign status   = {~busy, parked, er_err, pg_err, lv_err, 3'b000};

  AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_any) |-> $past(clr)) else $error("error flag dropped without clear"); // R9
  AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    bad_confirm |=> (er_err && pg_err && rmode == RM_STATUS)) else $error("bad confirm not flagged"); // R8
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BLK_W      = 2,
  parameter int PROG_CYC   = 12,
  parameter int ERASE_STEP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              vpp_ok,
  output logic              rd_vld,
  output logic [7:0]        rdata,
  output logic              rdy
);
  logic              cmd_wr, rd_acc;
  logic              start_prog, start_erase, park_req, resume;
  logic              busy, parked, fail_prog, fail_erase;
  logic [BLK_W-1:0]  park_blk;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata, mem_rd, host_rd;
  logic [7:0]        status, rd_next;
  logic [2:0]        err_bits;
  rmode_e            rmode;

  assign cmd_wr = ce && wr_en;
  assign rd_acc = ce && rd_en && !wr_en;

  fcs_cui u_cui (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(wdata),
    .busy(busy), .parked(parked), .fail_prog(fail_prog), .fail_erase(fail_erase),
    .start_prog(start_prog), .start_erase(start_erase), .park_req(park_req),
    .resume(resume), .rmode(rmode), .err_bits(err_bits), .status(status)
  );

  fcs_wsm #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .ERASE_STEP(ERASE_STEP)
  ) u_wsm (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .op_addr(addr), .op_data(wdata), .park_req(park_req), .resume(resume),
    .vpp_ok(vpp_ok), .mem_rd(mem_rd), .busy(busy), .parked(parked),
    .fail_prog(fail_prog), .fail_erase(fail_erase), .park_blk(park_blk),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_raddr(mem_raddr)
  );

  fcs_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(mem_raddr), .rdata_a(mem_rd), .raddr_b(addr), .rdata_b(host_rd)
  );

  always_comb begin
    rd_next = status;
    if (!busy) begin
      case (rmode)
        RM_ARRAY: begin
          if (parked && addr[ADDR_W-1 -: BLK_W] == park_blk) rd_next = status;
          else rd_next = host_rd;
        end
        RM_IDENT: rd_next = addr[0] ? ID_DEVICE : ID_MAKER;
        default:  rd_next = status;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rdata  <= 8'h00;
    end else begin
      rd_vld <= rd_acc;
      if (rd_acc) rdata <= rd_next;
    end
  end

  assign rdy = ~busy;

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(rd_acc)) else $error("read valid without strobe"); // R14
  AST_START_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(err_bits) == 3'b000)) else $error("operation started with error pending"); // R10
endmodule

// File: tb/tb_flash_cmd_status.sv
module tb_flash_cmd_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, wr_en = 1'b0, rd_en = 1'b0, vpp_ok = 1'b1;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       rd_vld, rdy;
  logic [7:0] rdata;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  flash_cmd_status dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .vpp_ok(vpp_ok),
    .rd_vld(rd_vld), .rdata(rdata), .rdy(rdy)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ce = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ce = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    ce = 1'b1; rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    ce = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wait_rdy(input int limit, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (rdy) begin seen = 1'b1; break; end
    end
    chk(seen, tag, int'(rdy), 1);
  endtask

  // monitor: pops the scoreboard on each valid read (R14)
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R14 unexpected rd_vld", int'(rdata), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata === e, t, int'(rdata), int'(e));
      end
    end
  end

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b1, "R1 rdy after reset", int'(rdy), 1);
    chk(rd_vld == 1'b0, "R14 no valid when idle", int'(rd_vld), 0);
    rd(8'h05, 8'hFF, "R1 array erased");
    rd(8'hC3, 8'hFF, "R1 array erased");

    cmd(8'h00, 8'h90);
    rd(8'h00, 8'h89, "R3 maker id");
    rd(8'h01, 8'hA2, "R3 device id");
    rd(8'h42, 8'h89, "R3 bit0 only");
    rd(8'h7F, 8'hA2, "R2 ident persists");
    cmd(8'h00, 8'h70);
    rd(8'h03, 8'h80, "R4 idle status");
    rd(8'h09, 8'h80, "R2 status persists");
    cmd(8'h00, 8'hFF);
    rd(8'h12, 8'hFF, "R2 back to array");

    // program with 40h, busy behaviour
    cmd(8'h12, 8'h40);
    cmd(8'h12, 8'h5A);
    chk(rdy == 1'b0, "R5 busy after data write", int'(rdy), 0);
    rd(8'h00, 8'h00, "R6 busy read is status");
    cmd(8'h00, 8'hFF);
    rd(8'h12, 8'h00, "R6 FF ignored while busy");
    wait_rdy(40, "R5 program finishes");
    rd(8'h12, 8'h80, "R6 status mode after program");
    cmd(8'h00, 8'hFF);
    rd(8'h12, 8'h5A, "R5 programmed byte");
    cmd(8'h00, 8'h10);
    cmd(8'h12, 8'hF0);
    wait_rdy(40, "R5 alternate setup finishes");
    cmd(8'h00, 8'hFF);
    rd(8'h12, 8'h50, "R5 AND merge");

    // invalid confirm
    cmd(8'h00, 8'h20);
    cmd(8'h00, 8'h33);
    rd(8'h00, 8'hB0, "R8 bad confirm flags");
    cmd(8'h00, 8'hFF);
    rd(8'h12, 8'h50, "R8 nothing erased");
    cmd(8'h00, 8'h70);
    rd(8'h00, 8'hB0, "R9 mode cmd keeps errors");

    // refusal while errors pending
    cmd(8'h00, 8'h40);
    cmd(8'h20, 8'h00);
    chk(rdy == 1'b1, "R10 program refused", int'(rdy), 1);
    rd(8'h00, 8'hB0, "R10 status unchanged");
    cmd(8'h00, 8'hFF);
    rd(8'h20, 8'hFF, "R10 byte untouched");
    cmd(8'h00, 8'h20);
    cmd(8'h00, 8'hD0);
    chk(rdy == 1'b1, "R10 erase refused", int'(rdy), 1);
    cmd(8'h00, 8'hFF);
    rd(8'h12, 8'h50, "R10 block kept");
    cmd(8'h00, 8'h50);
    cmd(8'h00, 8'h70);
    rd(8'h00, 8'h80, "R9 cleared by 50h");

    // erase block 1 selected by confirm address
    cmd(8'h45, 8'h40); cmd(8'h45, 8'h00); wait_rdy(40, "R5 program 45");
    cmd(8'h7F, 8'h40); cmd(8'h7F, 8'h3C); wait_rdy(40, "R5 program 7F");
    cmd(8'h00, 8'hFF);
    rd(8'h45, 8'h00, "R5 byte 45 programmed");
    cmd(8'h00, 8'h20);
    cmd(8'h40, 8'hD0);
    chk(rdy == 1'b0, "R7 erase busy", int'(rdy), 0);
    wait_rdy(400, "R7 erase finishes");
    rd(8'h00, 8'h80, "R7 status after erase");
    cmd(8'h00, 8'hFF);
    rd(8'h45, 8'hFF, "R7 block erased");
    rd(8'h7F, 8'hFF, "R7 block erased end");
    rd(8'h12, 8'h50, "R7 other block kept");

    // park and resume
    cmd(8'h85, 8'h40); cmd(8'h85, 8'h11); wait_rdy(40, "R5 program 85");
    cmd(8'h00, 8'h20);
    cmd(8'h80, 8'hD0);
    cmd(8'h00, 8'hB0);
    wait_rdy(20, "R12 park latency");
    rd(8'h00, 8'hC0, "R12 parked status");
    cmd(8'h00, 8'hFF);
    rd(8'h12, 8'h50, "R12 other block readable");
    rd(8'h85, 8'hC0, "R12 parked block gives status");
    cmd(8'h00, 8'h90);
    rd(8'h12, 8'h50, "R12 ident ignored when parked");
    cmd(8'h00, 8'hD0);
    chk(rdy == 1'b0, "R13 resume busy", int'(rdy), 0);
    rd(8'h00, 8'h00, "R13 bits 7 6 cleared");
    wait_rdy(400, "R13 erase completes");
    rd(8'h00, 8'h80, "R13 status after resume");
    cmd(8'h00, 8'hFF);
    rd(8'h85, 8'hFF, "R13 block erased");
    rd(8'hBF, 8'hFF, "R13 block end erased");

    // low program voltage
    vpp_ok = 1'b0;
    cmd(8'h00, 8'h40);
    cmd(8'h30, 8'h00);
    wait_rdy(20, "R11 program abort");
    rd(8'h00, 8'h98, "R11 program vpp flags");
    cmd(8'h00, 8'hFF);
    rd(8'h30, 8'hFF, "R11 nothing stored");
    cmd(8'h00, 8'h50);
    cmd(8'h00, 8'h20);
    cmd(8'h40, 8'hD0);
    wait_rdy(20, "R11 erase abort");
    rd(8'h00, 8'hA8, "R11 erase vpp flags");
    vpp_ok = 1'b1;
    cmd(8'h00, 8'h50);
    cmd(8'h00, 8'h70);
    rd(8'h00, 8'h80, "R9 cleared again");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R14 all reads returned", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule